// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only three-wire configuration port. A host lowers an active-low select line and clocks in a 16-bit frame, least significant bit first, on the serial data line. It then raises the select line. The three first-sent bits of the frame name a target register, and the frame is stored whole into that register. The stored registers are broken out into named control fields that drive the rest of the device: gain code, input path choice, power modes, bandwidth selections, clamp target, acquisition-loop controls, pulse polarity, output coding and a software reset.

The three serial lines are asynchronous to the system clock. Each line passes through a synchronizer, and the serial clock edges are detected in the system clock domain. A frame is accepted only if exactly sixteen serial clock rising edges were seen while select was low. The frame takes effect on the rising edge of select. Short frames, long frames and frames aimed at test addresses leave every register untouched.

A low-to-high change of the software reset bit emits a one-cycle calibration start pulse.

Top module: `sercfg_port`

## Requirements
- R1: After the asynchronous reset every field reads zero, with two exceptions: the clamp code reads 9 and soft_rst_o reads 1 (soft reset held). No calibration pulse is produced by reset.
- R2: sdi_i is sampled on each sck_i rising edge while cs_ni is low, and the first sampled bit becomes frame bit 0. Frame bits [1:0] select register index {b1,b0} when frame bit 2 is 0, and the whole frame is stored in that register.
- R3: A frame with fewer than 16 serial clocks before cs_ni rises changes no register.
- R4: A frame with more than 16 serial clocks before cs_ni rises changes no register.
- R5: A frame with bit 2 set is a test address. It changes no register and produces no calibration pulse.
- R6: A complete frame changes nothing while cs_ni is still low. The fields update only after the cs_ni rising edge.
- R7: sck_i edges while cs_ni is high are ignored and do not count toward the next frame.
- R8: Register 0 fields: gain_o = bits [12:3] and in_sel_o = bit 15.
- R9: Register 1 fields: sleep_o = bit 3, standby_o = bit 4, inv_lsbs_o = bit 5, inv_msb_o = bit 6, test_out_o = bit 7, sh_bw_o = bits [9:8], sw_bw_o = bits [13:10].
- R10: Register 2 fields: clamp_o = bits [7:3], fast_mult_o = bits [9:8], fast_hold_o = bits [11:10], low_pwr_o = bit 12, pulse_inv_o = bit 13, ob_inv_o = bit 14. soft_rst_o is the inverse of bit 15.
- R11: cal_start_o pulses high for exactly one clock when a write to register 2 changes bit 15 from 0 to 1. A write that leaves bit 15 at 1, or clears it, gives no pulse.
- R12: Register 3 fields: bias_off_o = bit 3, code_sel_o = bits [5:4], avg4_o = bit 6, ref_sel_o = bits [9:7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data, LSB first |
| gain_o | output | 10 | Gain code |
| in_sel_o | output | 1 | Input path select |
| sleep_o | output | 1 | Sleep mode |
| standby_o | output | 1 | Standby mode |
| inv_lsbs_o | output | 1 | Invert lower output bits |
| inv_msb_o | output | 1 | Invert top output bit |
| test_out_o | output | 1 | Output test mode |
| sh_bw_o | output | 2 | Hold amplifier bandwidth |
| sw_bw_o | output | 4 | Sampling switch time constant |
| clamp_o | output | 5 | Clamp target code |
| fast_mult_o | output | 2 | Fast acquisition gain multiplier |
| fast_hold_o | output | 2 | Fast acquisition hold-off |
| low_pwr_o | output | 1 | Low power mode |
| pulse_inv_o | output | 1 | Sampling pulse polarity inversion |
| ob_inv_o | output | 1 | Black window pulse inversion |
| soft_rst_o | output | 1 | Software reset asserted |
| cal_start_o | output | 1 | Calibration start pulse |
| bias_off_o | output | 1 | Center bias disable |
| code_sel_o | output | 2 | Output code type |
| avg4_o | output | 1 | Four-line averaging |
| ref_sel_o | output | 3 | Reference sample timing select |

## Verification
The bench walks a single one through every payload bit of each register. It also sends arithmetic patterns to each register and compares every field against a model.

A decoder that read the address from the wrong end of the frame, or a field taken from a shifted bit range, shows up as a mismatch in the wrong group.

Frames of 8, 15 and 17 clocks are sent. A counter that committed on a partial count, or wrapped past sixteen, would overwrite a register.

Test addresses are sent to confirm that a decoder that ignored bit 2 would clobber registers 0 to 3. Stray serial clocks are sent while select is high; a shifter that kept counting them would drop the next frame.

The fields are sampled between the sixteenth clock and the select rise, which catches a commit that fires on the count alone. The calibration pulse is counted across 0-to-1, 1-to-1 and 1-to-0 writes, which catches a level-driven or repeated pulse.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int FRAME_W  = 16;
  localparam int ADDR_W   = 3;
  localparam int SEL_W    = ADDR_W - 1;
  localparam int NUM_REGS = 1 << SEL_W;
  localparam int CNT_MAX  = FRAME_W + 1;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int RST_BIT  = 15;
  localparam int CAL_REG  = 2;
  localparam logic [4:0] CLAMP_DEFAULT = 5'd9;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [NUM_REGS-1:0][FRAME_W-1:0] regs_t;

  function automatic frame_t reg_default(input int idx);
    frame_t v;
    v = '0;
    if (idx == CAL_REG) v[7:3] = CLAMP_DEFAULT;
    return v;
  endfunction
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= {STAGES{RST_VAL}};
    end else begin
      st[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/sercfg_shifter.sv
module sercfg_shifter
  import sercfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_s_i,
  input  logic             sck_s_i,
  input  logic             sdi_s_i,
  output frame_t           frame_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             commit_o
);
  logic   sck_q, cs_q;
  logic   sck_rise, cs_rise;
  frame_t sr;
  logic [CNT_W-1:0] cnt;

  assign sck_rise = sck_s_i & ~sck_q;
  assign cs_rise  = cs_s_i & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      sr       <= '0;
      cnt      <= '0;
      commit_o <= 1'b0;
    end else begin
      sck_q    <= sck_s_i;
      cs_q     <= cs_s_i;
      commit_o <= cs_rise && (cnt == CNT_W'(FRAME_W));
      if (cs_s_i) begin
        cnt <= '0;
      end else if (sck_rise) begin
        sr <= {sdi_s_i, sr[FRAME_W-1:1]};
        // saturate one past a full frame so overlong frames never match
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame_o = sr;
  assign cnt_o   = cnt;
endmodule

// File: rtl/sercfg_regbank.sv
module sercfg_regbank
  import sercfg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   commit_i,
  input  frame_t frame_i,
  output regs_t  regs_o,
  output logic   cal_start_o
);
  logic             wr_ok;
  logic [SEL_W-1:0] sel;

  assign wr_ok = commit_i & ~frame_i[ADDR_W-1];
  assign sel   = frame_i[SEL_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_o[i] <= reg_default(i);
      else if (wr_ok && sel == SEL_W'(i))     regs_o[i] <= frame_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cal_start_o <= 1'b0;
    else         cal_start_o <= wr_ok && (sel == SEL_W'(CAL_REG)) &&
                                frame_i[RST_BIT] && !regs_o[CAL_REG][RST_BIT];
  end
endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
  import sercfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       sdi_i,
  output logic [9:0] gain_o,
  output logic       in_sel_o,
  output logic       sleep_o,
  output logic       standby_o,
  output logic       inv_lsbs_o,
  output logic       inv_msb_o,
  output logic       test_out_o,
  output logic [1:0] sh_bw_o,
  output logic [3:0] sw_bw_o,
  output logic [4:0] clamp_o,
  output logic [1:0] fast_mult_o,
  output logic [1:0] fast_hold_o,
  output logic       low_pwr_o,
  output logic       pulse_inv_o,
  output logic       ob_inv_o,
  output logic       soft_rst_o,
  output logic       cal_start_o,
  output logic       bias_off_o,
  output logic [1:0] code_sel_o,
  output logic       avg4_o,
  output logic [2:0] ref_sel_o
);
  logic             cs_s, sck_s, sdi_s;
  frame_t           frame;
  logic [CNT_W-1:0] bit_cnt;
  logic             commit;
  regs_t            regs;

  sercfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, sdi_i}),
    .q_o    ({cs_s, sck_s, sdi_s})
  );

  sercfg_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_s_i   (cs_s),
    .sck_s_i  (sck_s),
    .sdi_s_i  (sdi_s),
    .frame_o  (frame),
    .cnt_o    (bit_cnt),
    .commit_o (commit)
  );

  sercfg_regbank u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit),
    .frame_i     (frame),
    .regs_o      (regs),
    .cal_start_o (cal_start_o)
  );

  assign gain_o      = regs[0][12:3];
  assign in_sel_o    = regs[0][15];

  assign sleep_o     = regs[1][3];
  assign standby_o   = regs[1][4];
  assign inv_lsbs_o  = regs[1][5];
  assign inv_msb_o   = regs[1][6];
  assign test_out_o  = regs[1][7];
  assign sh_bw_o     = regs[1][9:8];
  assign sw_bw_o     = regs[1][13:10];

  assign clamp_o     = regs[2][7:3];
  assign fast_mult_o = regs[2][9:8];
  assign fast_hold_o = regs[2][11:10];
  assign low_pwr_o   = regs[2][12];
  assign pulse_inv_o = regs[2][13];
  assign ob_inv_o    = regs[2][14];
  assign soft_rst_o  = ~regs[2][RST_BIT];

  assign bias_off_o  = regs[3][3];
  assign code_sel_o  = regs[3][5:4];
  assign avg4_o      = regs[3][6];
  assign ref_sel_o   = regs[3][9:7];

  logic unused_bits;
  assign unused_bits = ^{regs[0][14:13], regs[0][2:0], regs[1][15:14], regs[1][2:0],
                         regs[2][2:0], regs[3][15:10], regs[3][2:0]};
endmodule

// File: rtl/sercfg_chk.sv
module sercfg_chk
  import sercfg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_s,
  input logic             commit,
  input frame_t           frame,
  input logic [CNT_W-1:0] bit_cnt,
  input regs_t            regs,
  input logic             cal_start
);
  a_r6_hold_without_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(regs));

  a_r3_commit_needs_full_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> $past(bit_cnt) == CNT_W'(FRAME_W));

  a_r5_test_addr_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && frame[ADDR_W-1]) |=> $stable(regs));

  a_r7_idle_count_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> bit_cnt == '0);

  a_r11_cal_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start |=> !cal_start);

  a_r11_cal_from_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start |-> ($past(commit) && $past(frame[RST_BIT])));
endmodule

bind sercfg_port sercfg_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_s      (cs_s),
  .commit    (commit),
  .frame     (frame),
  .bit_cnt   (bit_cnt),
  .regs      (regs),
  .cal_start (cal_start_o)
);

// File: tb/sercfg_port_bench.sv
module sercfg_port_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, sdi = 1'b0;

  logic [9:0] gain_o;
  logic in_sel_o, sleep_o, standby_o, inv_lsbs_o, inv_msb_o, test_out_o;
  logic [1:0] sh_bw_o;
  logic [3:0] sw_bw_o;
  logic [4:0] clamp_o;
  logic [1:0] fast_mult_o, fast_hold_o, code_sel_o;
  logic low_pwr_o, pulse_inv_o, ob_inv_o, soft_rst_o, cal_start_o, bias_off_o, avg4_o;
  logic [2:0] ref_sel_o;

  always #10 clk = ~clk;

  sercfg_port u_sercfg_port (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .sdi_i(sdi),
    .gain_o(gain_o), .in_sel_o(in_sel_o), .sleep_o(sleep_o), .standby_o(standby_o),
    .inv_lsbs_o(inv_lsbs_o), .inv_msb_o(inv_msb_o), .test_out_o(test_out_o),
    .sh_bw_o(sh_bw_o), .sw_bw_o(sw_bw_o), .clamp_o(clamp_o), .fast_mult_o(fast_mult_o),
    .fast_hold_o(fast_hold_o), .low_pwr_o(low_pwr_o), .pulse_inv_o(pulse_inv_o),
    .ob_inv_o(ob_inv_o), .soft_rst_o(soft_rst_o), .cal_start_o(cal_start_o),
    .bias_off_o(bias_off_o), .code_sel_o(code_sel_o), .avg4_o(avg4_o), .ref_sel_o(ref_sel_o)
  );

  int checks = 0, fails = 0, cal_cnt = 0, exp_cal = 0;
  logic [15:0] m [4];

  always @(negedge clk) if (rst_ni && cal_start_o) cal_cnt++;

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " R8 reg0 fields"}, {in_sel_o, gain_o}, {m[0][15], m[0][12:3]});
    chk({req, " R9 reg1 fields"},
        {sw_bw_o, sh_bw_o, test_out_o, inv_msb_o, inv_lsbs_o, standby_o, sleep_o}, m[1][13:3]);
    chk({req, " R10 reg2 fields"},
        {soft_rst_o, ob_inv_o, pulse_inv_o, low_pwr_o, fast_hold_o, fast_mult_o, clamp_o},
        {~m[2][15], m[2][14:3]});
    chk({req, " R12 reg3 fields"}, {ref_sel_o, avg4_o, code_sel_o, bias_off_o}, m[3][9:3]);
    chk({req, " R11 cal pulses"}, cal_cnt, exp_cal);
  endtask

  task automatic sck_idle_toggles(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (3) @(negedge clk); sck = 1'b1;
      repeat (3) @(negedge clk); sck = 1'b0;
    end
  endtask

  task automatic shift_bits(input logic [15:0] f, input int n);
    @(negedge clk); cs_ni = 1'b0;
    for (int i = 0; i < n; i++) begin
      sdi = f[i % 16];
      repeat (3) @(negedge clk); sck = 1'b1;
      repeat (3) @(negedge clk); sck = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic end_frame(input logic [15:0] f, input int n);
    cs_ni = 1'b1;
    if (n == 16 && !f[2]) begin
      if (f[1:0] == 2'd2 && f[15] && !m[2][15]) exp_cal++;
      m[f[1:0]] = f;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] f, input int n);
    shift_bits(f, n);
    end_frame(f, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) m[r] = 16'h0;
    m[2] = 16'h0048;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset defaults
    chk("R1 clamp default", clamp_o, 5'd9);
    chk("R1 soft reset held", soft_rst_o, 1'b1);
    check_all("R1");

    // R2 walking one over every payload bit of each register
    for (int r = 0; r < 4; r++)
      for (int b = 3; b < 16; b++) begin
        send((16'h1 << b) | 16'(r), 16);
        check_all("R2 walk");
      end

    // R2 arithmetic patterns per register
    for (int r = 0; r < 4; r++)
      for (int k = 1; k < 9; k++) begin
        send(((16'(k) * 16'h9E37) & 16'hFFF8) | 16'(r), 16);
        check_all("R2 pattern");
      end

    // R3 short frames
    send(16'hA5A8, 15); check_all("R3 15 clocks");
    send(16'h5A51, 8);  check_all("R3 8 clocks");
    // R4 long frame
    send(16'hFFF8, 17); check_all("R4 17 clocks");
    send(16'h3C3A, 24); check_all("R4 24 clocks");

    // R5 test addresses (bit 2 set)
    for (int a = 4; a < 8; a++) begin
      send(16'hFFF8 | 16'(a), 16);
      check_all("R5 test address");
    end

    // R6 no change before select rises
    shift_bits(16'h1238, 16);
    check_all("R6 before select rise");
    end_frame(16'h1238, 16);
    check_all("R6 after select rise");

    // R7 stray clocks while idle, then a valid frame
    sck_idle_toggles(5);
    send(16'h4BD1, 16);
    check_all("R7 after idle clocks");

    // R11 calibration pulse edge cases
    send(16'h0002, 16); check_all("R11 clear bit15");
    send(16'h8002, 16); check_all("R11 rise bit15");
    send(16'h8F02, 16); check_all("R11 bit15 stays high");
    send(16'h0F02, 16); check_all("R11 fall bit15");
    send(16'h8006, 16); check_all("R11 test address no pulse");
    send(16'h8002, 16); check_all("R11 second rise");

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule